// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a display. Every period is an input set at run time: the sync width, the delay from sync to the visible window, the visible length and the total length, each given separately for the horizontal axis (in pixels) and the vertical axis (in lines). A pixel counter and a line counter run on the pixel clock. From them the block derives horizontal and vertical sync, a composite sync, a visible-area gate, a blanking signal, and one-cycle end-of-line and end-of-frame strobes.

Each line starts with its sync pulse. The gate-delay period follows, then the visible window, and blanking fills the rest of the line up to the total length. Frames follow the same order, counted in lines. The video enable input works as a synchronous reset. While it is low, both counters are held at the first pixel of the first line and every output is held inactive. Settings may only change while video is disabled.

Top module: `vid_timing_gen`

## Requirements
- R1: `hsync` is at its active level (equal to `hs_pol`) during pixels 0 to `hs_width`-1 of every line and at the opposite level elsewhere; a width of 0 gives no pulse.
- R2: `vsync` is at its active level (equal to `vs_pol`) on every pixel of lines 0 to `vs_width`-1 of a frame and at the opposite level elsewhere.
- R3: `csync` is at its active level (equal to `cs_pol`) exactly when the raw horizontal sync or the raw vertical sync is active; the polarity is applied after the OR.
- R4: `active` is 1 exactly when the pixel index lies in [`hs_width`+`hs_delay`, `hs_width`+`hs_delay`+`hs_active`) and the line index lies in [`vs_width`+`vs_delay`, `vs_width`+`vs_delay`+`vs_active`).
- R5: `blank` equals `blank_pol` whenever `active` is 0 and equals the inverse of `blank_pol` whenever `active` is 1.
- R6: `line_end` is 1 for exactly one clock, on the last pixel (index `hs_total`-1) of each line.
- R7: `frame_end` is 1 only on the last pixel of the last line (index `vs_total`-1), together with `line_end`.
- R8: While `video_en` is low, the counters return to pixel 0 of line 0 and the outputs hold `line_end`=0, `frame_end`=0, `active`=0, `blank`=`blank_pol`, and `hsync`, `vsync`, `csync` at their inactive levels. The edge at which `video_en` is first seen high produces pixel 0 of line 0.
- R9: The line counter advances only when the pixel counter wraps, so `vsync` changes only on the first pixel of a line.
- R10: The four polarity inputs are independent. Setting one to 0 inverts only its own output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| video_en | input | 1 | Video enable; low acts as synchronous reset |
| hs_pol | input | 1 | Horizontal sync active level |
| hs_width | input | SYNC_W | Horizontal sync width in pixels |
| hs_delay | input | SYNC_W | Pixels from end of sync to visible window |
| hs_active | input | LEN_W | Visible pixels per line |
| hs_total | input | LEN_W | Total pixels per line |
| vs_pol | input | 1 | Vertical sync active level |
| vs_width | input | SYNC_W | Vertical sync width in lines |
| vs_delay | input | SYNC_W | Lines from end of sync to visible window |
| vs_active | input | LEN_W | Visible lines per frame |
| vs_total | input | LEN_W | Total lines per frame |
| cs_pol | input | 1 | Composite sync active level |
| blank_pol | input | 1 | Blank active level |
| line_end | output | 1 | One-cycle strobe on last pixel of a line |
| frame_end | output | 1 | One-cycle strobe on last pixel of a frame |
| active | output | 1 | Visible-area gate |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| blank | output | 1 | Blanking signal |

## Verification
The hardest cases to reach are the frame wrap, where both counters roll over on the same edge, and a disable that arrives partway through a frame. The bench uses small totals, so the last line of a frame comes within a few dozen cycles and several full frames run in each configuration. It drops `video_en` in the middle of a frame and checks that the next enabled edge starts again at pixel 0 of line 0. Further configurations cover a zero sync width, a zero gate delay and a visible window that reaches the last pixel of the line, and each of these runs with mixed polarities.

// File: rtl/vid_timing_gen.sv
module vid_timing_gen #(
  parameter int SYNC_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              video_en,
  input  logic              hs_pol,
  input  logic [SYNC_W-1:0] hs_width,
  input  logic [SYNC_W-1:0] hs_delay,
  input  logic [LEN_W-1:0]  hs_active,
  input  logic [LEN_W-1:0]  hs_total,
  input  logic              vs_pol,
  input  logic [SYNC_W-1:0] vs_width,
  input  logic [SYNC_W-1:0] vs_delay,
  input  logic [LEN_W-1:0]  vs_active,
  input  logic [LEN_W-1:0]  vs_total,
  input  logic              cs_pol,
  input  logic              blank_pol,
  output logic              line_end,
  output logic              frame_end,
  output logic              active,
  output logic              hsync,
  output logic              vsync,
  output logic              csync,
  output logic              blank
);
  localparam int SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] hcnt, vcnt;

  wire [LEN_W-1:0] h_max = hs_total - 1'b1;
  wire [LEN_W-1:0] v_max = vs_total - 1'b1;
  wire h_last = hcnt == h_max;
  wire v_last = vcnt == v_max;

  wire [SUM_W-1:0] h_on_at  = SUM_W'(hs_width) + SUM_W'(hs_delay);
  wire [SUM_W-1:0] h_off_at = h_on_at + SUM_W'(hs_active);
  wire [SUM_W-1:0] v_on_at  = SUM_W'(vs_width) + SUM_W'(vs_delay);
  wire [SUM_W-1:0] v_off_at = v_on_at + SUM_W'(vs_active);

  wire [SUM_W-1:0] h_pos = SUM_W'(hcnt);
  wire [SUM_W-1:0] v_pos = SUM_W'(vcnt);

  wire h_sync_raw = h_pos < SUM_W'(hs_width);
  wire v_sync_raw = v_pos < SUM_W'(vs_width);
  wire h_win      = (h_pos >= h_on_at) && (h_pos < h_off_at);
  wire v_win      = (v_pos >= v_on_at) && (v_pos < v_off_at);
  wire gate_raw   = h_win && v_win;

  always_ff @(posedge clk) begin
    if (!video_en) begin
      hcnt      <= '0;
      vcnt      <= '0;
      line_end  <= 1'b0;
      frame_end <= 1'b0;
      active    <= 1'b0;
      hsync     <= ~hs_pol;
      vsync     <= ~vs_pol;
      csync     <= ~cs_pol;
      blank     <= blank_pol;
    end else begin
      hcnt <= h_last ? '0 : hcnt + 1'b1;
      if (h_last)
        vcnt <= v_last ? '0 : vcnt + 1'b1;
      line_end  <= h_last;
      frame_end <= h_last && v_last;
      active    <= gate_raw;
      hsync     <= h_sync_raw ~^ hs_pol;
      vsync     <= v_sync_raw ~^ vs_pol;
      csync     <= (h_sync_raw || v_sync_raw) ~^ cs_pol;
      blank     <= ~gate_raw ~^ blank_pol;
    end
  end
endmodule

// File: rtl/vid_timing_gen_chk.sv
module vid_timing_gen_chk #(
  parameter int SYNC_W = 8,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              video_en,
  input logic              hs_pol,
  input logic [SYNC_W-1:0] hs_width,
  input logic [LEN_W-1:0]  hs_total,
  input logic              vs_pol,
  input logic              cs_pol,
  input logic              blank_pol,
  input logic              line_end,
  input logic              frame_end,
  input logic              active,
  input logic              hsync,
  input logic              vsync,
  input logic              csync,
  input logic              blank
);
  logic was_en = 1'b0;
  always_ff @(posedge clk) was_en <= video_en;

  a_r6_line_end_single: assert property (@(posedge clk) disable iff (!video_en)
    (was_en && line_end && hs_total > 1) |=> !line_end);

  a_r7_frame_with_line: assert property (@(posedge clk) disable iff (!video_en)
    frame_end |-> line_end);

  a_r1_sync_after_wrap: assert property (@(posedge clk) disable iff (!video_en)
    (was_en && line_end && hs_width != '0) |=> (hsync == hs_pol));

  a_r9_vsync_line_steady: assert property (@(posedge clk) disable iff (!video_en)
    (was_en && !line_end) |=> $stable(vsync));

  a_r3_csync_is_or: assert property (@(posedge clk) disable iff (!video_en)
    was_en |-> ((csync == cs_pol) == ((hsync == hs_pol) || (vsync == vs_pol))));

  a_r5_blank_vs_gate: assert property (@(posedge clk) disable iff (!video_en)
    was_en |-> ((blank == blank_pol) != active));

  a_r8_quiet_when_off: assert property (@(posedge clk)
    !video_en |=> (!line_end && !frame_end && !active));
endmodule

bind vid_timing_gen vid_timing_gen_chk #(.SYNC_W(SYNC_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .video_en(video_en), .hs_pol(hs_pol), .hs_width(hs_width),
  .hs_total(hs_total), .vs_pol(vs_pol), .cs_pol(cs_pol), .blank_pol(blank_pol),
  .line_end(line_end), .frame_end(frame_end), .active(active), .hsync(hsync),
  .vsync(vsync), .csync(csync), .blank(blank)
);

// File: tb/vid_timing_gen_test.sv
module vid_timing_gen_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        video_en = 1'b0;
  logic        hs_pol = 1'b1, vs_pol = 1'b1, cs_pol = 1'b1, blank_pol = 1'b1;
  logic [7:0]  hs_width = 8'd2, hs_delay = 8'd1, vs_width = 8'd1, vs_delay = 8'd1;
  logic [15:0] hs_active = 16'd6, hs_total = 16'd12, vs_active = 16'd3, vs_total = 16'd6;
  logic line_end, frame_end, active, hsync, vsync, csync, blank;

  vid_timing_gen uut (
    .clk(clk), .video_en(video_en),
    .hs_pol(hs_pol), .hs_width(hs_width), .hs_delay(hs_delay),
    .hs_active(hs_active), .hs_total(hs_total),
    .vs_pol(vs_pol), .vs_width(vs_width), .vs_delay(vs_delay),
    .vs_active(vs_active), .vs_total(vs_total),
    .cs_pol(cs_pol), .blank_pol(blank_pol),
    .line_end(line_end), .frame_end(frame_end), .active(active),
    .hsync(hsync), .vsync(vsync), .csync(csync), .blank(blank)
  );

  typedef struct packed {
    logic rst, le, fe, act, hs, vs, cs, bl;
  } item_t;

  item_t exp_q[$];
  int total = 0, bad = 0;
  int h = 0, v = 0;
  bit done = 0;

  function automatic item_t model(int hp, int vp);
    item_t e;
    bit hr, vr, hg, vg;
    hr = hp < int'(hs_width);
    vr = vp < int'(vs_width);
    hg = hp >= int'(hs_width) + int'(hs_delay) && hp < int'(hs_width) + int'(hs_delay) + int'(hs_active);
    vg = vp >= int'(vs_width) + int'(vs_delay) && vp < int'(vs_width) + int'(vs_delay) + int'(vs_active);
    e.rst = 0;
    e.le  = hp == int'(hs_total) - 1;
    e.fe  = e.le && vp == int'(vs_total) - 1;
    e.act = hg && vg;
    e.hs  = hr ? hs_pol : ~hs_pol;
    e.vs  = vr ? vs_pol : ~vs_pol;
    e.cs  = (hr || vr) ? cs_pol : ~cs_pol;
    e.bl  = (hg && vg) ? ~blank_pol : blank_pol;
    return e;
  endfunction

  task automatic hold_off(int n);
    for (int i = 0; i < n; i++) begin
      item_t e;
      video_en = 1'b0;
      e.rst = 1; e.le = 0; e.fe = 0; e.act = 0;
      e.hs = ~hs_pol; e.vs = ~vs_pol; e.cs = ~cs_pol; e.bl = blank_pol;
      exp_q.push_back(e);
      @(posedge clk); #1;
    end
    h = 0; v = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      video_en = 1'b1;
      exp_q.push_back(model(h, v));
      @(posedge clk); #1;
      if (h == int'(hs_total) - 1) begin
        h = 0;
        v = (v == int'(vs_total) - 1) ? 0 : v + 1;
      end else h++;
    end
  endtask

  task automatic check(string tag, logic act_v, logic exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        if (e.rst) begin
          check("R8 line_end", line_end, e.le);
          check("R8 frame_end", frame_end, e.fe);
          check("R8 active", active, e.act);
          check("R8 hsync", hsync, e.hs);
          check("R8 vsync", vsync, e.vs);
          check("R8 csync", csync, e.cs);
          check("R8 blank", blank, e.bl);
        end else begin
          check("R6 line_end", line_end, e.le);
          check("R7 frame_end", frame_end, e.fe);
          check("R4 active", active, e.act);
          check("R1 R10 hsync", hsync, e.hs);
          check("R2 R9 vsync", vsync, e.vs);
          check("R3 R10 csync", csync, e.cs);
          check("R5 R10 blank", blank, e.bl);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    // R8: reset state, then start at pixel 0 of line 0
    hold_off(3);
    run(2 * 72 + 5);
    // R8: disable mid-frame, restart from origin
    hold_off(2);
    run(30);
    // R10: mixed polarities, zero sync width, zero vertical delay
    hold_off(1);
    hs_pol = 1'b0; vs_pol = 1'b1; cs_pol = 1'b0; blank_pol = 1'b0;
    hs_width = 8'd0; hs_delay = 8'd3; hs_active = 16'd4; hs_total = 16'd9;
    vs_width = 8'd2; vs_delay = 8'd0; vs_active = 16'd3; vs_total = 16'd5;
    hold_off(2);
    run(2 * 45 + 3);
    // R4: visible window reaching the last pixel and last line
    hs_pol = 1'b1; vs_pol = 1'b0; cs_pol = 1'b1; blank_pol = 1'b0;
    hs_width = 8'd1; hs_delay = 8'd1; hs_active = 16'd6; hs_total = 16'd8;
    vs_width = 8'd1; vs_delay = 8'd0; vs_active = 16'd3; vs_total = 16'd4;
    hold_off(2);
    run(2 * 32 + 4);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule